// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits between a processor's memory port and a page-mode DRAM. For every access the processor also gives a sequential hint. A plain (non-sequential) access opens a DRAM page. It presents the row address, asserts the row strobe, then runs the column phase and the data clock, which takes four clocks. When the hint is set and the requested row equals the row already held open, the row phase is skipped. The access then takes two clocks: the column strobe and the data clock. Multi-register loads and stores issue their transfers as runs of sequential accesses, so a whole burst proceeds at twice the rate of isolated accesses.

The processor holds a request (address, direction, write data, hint) and watches `cpu_ready`, which is high only in the data clock of an access. The sequencer samples the request inputs at the close of an idle clock or a data clock. A processor that wants back-to-back transfers therefore places its next request on the inputs during the clock in which it sees `cpu_ready`. When no request is waiting, the page is closed: the row strobe is released and the next access is full length even if it carries the hint. The word address is split with the row in the upper `ROW_W` bits and the column in the lower `COL_W` bits. Both are driven right-justified on the shared DRAM address bus.

Top module: `pagemode_seq`

## Requirements
- R1: While reset is asserted and after its release with no request, dram_ras_n, dram_cas_n and dram_we_n are 1, and cpu_ready is 0.
- R2: A non-sequential access takes exactly four clocks after it is sampled. The clocks are: row address with row strobe high; row address held with row strobe low; column strobe low with column address; data clock. A non-sequential request is always full length, even into the open row. The column strobe is never low while the row strobe is high.
- R3: A request with the sequential hint set, whose row equals the open row, takes exactly two clocks: column strobe low with column address, then the data clock. The row strobe stays low across the whole run.
- R4: A sequential-hinted request whose row differs from the open row falls back to the full four-clock access of R2.
- R5: After an idle clock the page is closed, so a sequential-hinted request then takes the full four-clock access.
- R6: The row strobe is high in every idle clock and in the row-address clock of each full access.
- R7: cpu_ready is 1 for exactly one clock per access, the data clock, and never in two consecutive clocks.
- R8: dram_we_n is 0 only in the column-strobe clock of a write access. dram_wdata then carries that access's write data.
- R9: In the data clock of a read, cpu_rdata equals dram_rdata (the addressed word). In all other clocks and for writes it is 0.
- R10: Request inputs are sampled only at the close of an idle or data clock. Changes to them during the other clocks of an access have no effect.
- R11: The row is cpu_addr[ROW_W+COL_W-1:COL_W] and the column is cpu_addr[COL_W-1:0]. Each is driven zero-extended on dram_addr in its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_req | input | 1 | Access request held by the processor |
| cpu_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| cpu_seq | input | 1 | Sequential hint: request continues the open page |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid in the data clock |
| cpu_ready | output | 1 | High in the data clock of each access |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_we_n | output | 1 | Write enable, active low |
| dram_wdata | output | DATA_W | Data toward the DRAM |
| dram_rdata | input | DATA_W | Data from the DRAM |

## Verification
Properties checked on every clock cover the strobe relations: the column strobe and the write enable only appear inside an open row, the row address is held across the strobe's falling clock, and the page is released after a clock with no request. The same properties check that a page hit goes straight to the column strobe, that a miss starts with the row strobe high, that the data clock is a single pulse right after the column strobe, and that read data is quiet outside it. Only the bench's scenarios show the access lengths of whole bursts. They also show that data written in one sequential run reads back through another, that a hint after an idle clock or into a different row still costs four clocks, and that inputs wiggled mid-access are ignored.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ROW   = 3'd1,
    ST_RHOLD = 3'd2,
    ST_COL   = 3'd3,
    ST_DATA  = 3'd4
  } pms_state_e;
endpackage

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       hit,
  output pms_state_e state,
  output logic       take,
  output logic       close
);
  pms_state_e state_d;
  logic       free;

  // A request is accepted at the end of an idle clock or a data clock.
  always_comb begin
    free    = (state == ST_IDLE) || (state == ST_DATA);
    take    = free && req;
    close   = free && !req;
    state_d = state;
    unique case (state)
      ST_IDLE, ST_DATA: begin
        if (req) state_d = hit ? ST_COL : ST_ROW;
        else     state_d = ST_IDLE;
      end
      ST_ROW:   state_d = ST_RHOLD;
      ST_RHOLD: state_d = ST_COL;
      ST_COL:   state_d = ST_DATA;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/pms_page.sv
module pms_page #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             close,
  input  logic             seq,
  input  logic [ROW_W-1:0] row_in,
  output logic             hit
);
  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             en;

  // Page state changes only when a request is taken or the bus goes idle.
  always_comb begin
    en     = take || close;
    open_d = take;
    row_d  = take ? row_in : row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (en) begin
      open_q <= open_d;
      row_q  <= row_d;
    end
  end

  assign hit = open_q && seq && (row_in == row_q);
endmodule

// File: rtl/pms_latch.sv
module pms_latch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic              we_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (take) begin
      addr_q  <= addr;
      we_q    <= we;
      wdata_q <= wdata;
    end
  end
endmodule

// File: rtl/pagemode_seq.sv
module pagemode_seq
  import pms_pkg::*;
#(
  parameter  int ROW_W  = 8,
  parameter  int COL_W  = 8,
  parameter  int DATA_W = 32,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_seq,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic [MA_W-1:0]   dram_addr,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic [DATA_W-1:0] dram_rdata
);
  pms_state_e        state;
  logic              take, close, hit;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;

  pms_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(cpu_req), .hit(hit),
    .state(state), .take(take), .close(close)
  );

  pms_page #(.ROW_W(ROW_W)) u_page (
    .clk(clk), .rst_n(rst_n), .take(take), .close(close), .seq(cpu_seq),
    .row_in(cpu_addr[ADDR_W-1:COL_W]), .hit(hit)
  );

  pms_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .take(take), .addr(cpu_addr), .we(cpu_we),
    .wdata(cpu_wdata), .addr_q(addr_q), .we_q(we_q), .wdata_q(wdata_q)
  );

  assign row_q = addr_q[ADDR_W-1:COL_W];
  assign col_q = addr_q[COL_W-1:0];

  // Strobes and address mux decoded from the phase.
  always_comb begin
    dram_ras_n = !((state == ST_RHOLD) || (state == ST_COL) || (state == ST_DATA));
    dram_cas_n = (state != ST_COL);
    dram_we_n  = !((state == ST_COL) && we_q);
    cpu_ready  = (state == ST_DATA);
    if ((state == ST_ROW) || (state == ST_RHOLD)) dram_addr = MA_W'(row_q);
    else                                          dram_addr = MA_W'(col_q);
    cpu_rdata  = (cpu_ready && !we_q) ? dram_rdata : '0;
  end

  assign dram_wdata = wdata_q;

  p_cas_in_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  p_row_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && $past(dram_ras_n)) |-> $stable(dram_addr));
  p_hit_skips_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit) |=> (!dram_cas_n && !dram_ras_n));
  p_miss_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hit) |=> (dram_ras_n && !cpu_ready));
  p_idle_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> dram_ras_n);
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  p_ready_after_cas_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> $past(!dram_cas_n));
  p_we_in_cas_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !dram_cas_n);
  p_rdata_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> (cpu_rdata == '0));
endmodule

// File: tb/sim_pagemode_seq.sv
`timescale 1ns/1ps
module sim_pagemode_seq;
  localparam int RW = 4;
  localparam int CW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_seq, cpu_we;
  logic [7:0]    cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, dram_wdata, dram_rdata;
  logic          cpu_ready, dram_ras_n, dram_cas_n, dram_we_n;
  logic [3:0]    dram_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pagemode_seq #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_seq(cpu_seq), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_addr(dram_addr), .dram_we_n(dram_we_n),
    .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural DRAM: row latched when the row strobe falls, column on column strobe.
  logic [DW-1:0] bmem [256];
  logic [DW-1:0] gold [256];
  logic [3:0]    brow = '0, bcol = '0;
  bit            last_ras = 1'b1;
  initial for (int i = 0; i < 256; i++) begin
    bmem[i] = DW'(i * 37 + 5);
    gold[i] = DW'(i * 37 + 5);
  end
  assign dram_rdata = bmem[{brow, bcol}];
  always @(negedge clk) begin
    if (!dram_ras_n && last_ras) brow = dram_addr;
    if (!dram_cas_n) begin
      bcol = dram_addr;
      if (!dram_we_n) bmem[{brow, bcol}] = dram_wdata;
    end
    last_ras = dram_ras_n;
  end

  // Reference model: queue of expected per-clock outputs.
  typedef struct { bit ras_n; bit cas_n; bit we_n; bit rdy; int ma; int rd; } step_t;
  step_t q[$];
  bit    open_v = 0;
  int    open_row = 0;
  bit    m_free, m_hit;
  int    m_r, m_c, m_i;

  function automatic step_t mk(bit a, bit b, bit c, bit d, int m, int r);
    step_t s;
    s.ras_n = a; s.cas_n = b; s.we_n = c; s.rdy = d; s.ma = m; s.rd = r;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      open_v = 0;
    end else begin
      m_free = (q.size() == 0) || q[0].rdy;
      if (q.size() != 0) void'(q.pop_front());
      if (m_free) begin
        if (cpu_req) begin
          m_r = int'(cpu_addr[7:4]);
          m_c = int'(cpu_addr[3:0]);
          m_i = int'(cpu_addr);
          m_hit = open_v && cpu_seq && (m_r == open_row);
          if (!m_hit) begin
            q.push_back(mk(1, 1, 1, 0, m_r, 0));
            q.push_back(mk(0, 1, 1, 0, m_r, 0));
          end
          q.push_back(mk(0, 0, !cpu_we, 0, m_c, 0));
          q.push_back(mk(0, 1, 1, 1, m_c, cpu_we ? 0 : int'(gold[m_i])));
          if (cpu_we) gold[m_i] = cpu_wdata;
          open_v = 1;
          open_row = m_r;
        end else begin
          open_v = 0;
        end
      end
    end
  end

  step_t e;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() == 0) e = mk(1, 1, 1, 0, 0, 0);
      else               e = q[0];
      chk(dram_ras_n == e.ras_n, "R6 ras_n", int'(dram_ras_n), int'(e.ras_n));
      chk(dram_cas_n == e.cas_n, "R2 cas_n", int'(dram_cas_n), int'(e.cas_n));
      chk(dram_we_n == e.we_n, "R8 we_n", int'(dram_we_n), int'(e.we_n));
      chk(cpu_ready == e.rdy, "R7 ready", int'(cpu_ready), int'(e.rdy));
      chk(int'(cpu_rdata) == e.rd, "R9 rdata", int'(cpu_rdata), e.rd);
      if (q.size() != 0)
        chk(int'(dram_addr) == e.ma, "R11 dram_addr", int'(dram_addr), e.ma);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL R7 watchdog act=0 exp=1");
    finish_run();
  end

  // Drive one access at a negedge; return clocks to ready and the first address shown.
  task automatic do_acc(input int r, input int c, input bit s, input bit w,
                        input int d, input bit noise, output int n, output int ma0);
    cpu_req = 1; cpu_addr = 8'((r << 4) | c); cpu_seq = s; cpu_we = w;
    cpu_wdata = DW'(d); n = 0; ma0 = -1;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        ma0 = int'(dram_addr);
        if (noise) begin
          cpu_addr = ~cpu_addr; cpu_we = ~cpu_we; cpu_seq = ~cpu_seq;
          cpu_wdata = ~cpu_wdata;
        end
      end
    end while (!cpu_ready && n < 20);
  endtask

  int n, ma;
  initial begin
    rst_n = 0; cpu_req = 0; cpu_addr = '0; cpu_seq = 0; cpu_we = 0; cpu_wdata = '0;
    repeat (2) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && !cpu_ready, "R1 reset outputs",
        int'({dram_ras_n, dram_cas_n, dram_we_n, cpu_ready}), 14);
    rst_n = 1;
    @(negedge clk);
    chk(dram_ras_n && !cpu_ready, "R1 idle after reset", int'(dram_ras_n), 1);

    do_acc(3, 2, 0, 1, 16'hA5A5, 0, n, ma);
    chk(n == 4, "R2 non-seq write length", n, 4);
    chk(ma == 3, "R11 row on bus first", ma, 3);
    for (int k = 3; k < 6; k++) begin
      do_acc(3, k, 1, 1, 16'h1111 * k, 0, n, ma);
      chk(n == 2, "R3 seq write length", n, 2);
      chk(ma == k, "R11 column on bus first", ma, k);
    end
    cpu_req = 0;
    @(negedge clk);
    chk(dram_ras_n == 1, "R6 released when idle", int'(dram_ras_n), 1);

    do_acc(3, 2, 1, 0, 0, 0, n, ma);
    chk(n == 4, "R5 seq after idle is full", n, 4);
    chk(cpu_rdata == 16'hA5A5, "R9 read back", int'(cpu_rdata), 16'hA5A5);
    for (int k = 3; k < 6; k++) begin
      do_acc(3, k, 1, 0, 0, 0, n, ma);
      chk(n == 2, "R3 seq read length", n, 2);
      chk(cpu_rdata == 16'(16'h1111 * k), "R9 burst read data", int'(cpu_rdata),
          int'(16'(16'h1111 * k)));
    end
    do_acc(7, 0, 1, 0, 0, 0, n, ma);
    chk(n == 4, "R4 seq row mismatch full", n, 4);
    do_acc(7, 1, 0, 1, 16'h0BEE, 0, n, ma);
    chk(n == 4, "R2 non-seq into open row full", n, 4);
    do_acc(7, 2, 1, 1, 16'h3C3C, 1, n, ma);
    chk(n == 2, "R10 noise mid-access ignored", n, 2);
    do_acc(7, 2, 1, 0, 0, 0, n, ma);
    chk(cpu_rdata == 16'h3C3C, "R10 latched data kept", int'(cpu_rdata), 16'h3C3C);
    do_acc(0, 15, 0, 1, 16'h5151, 0, n, ma);
    do_acc(0, 0, 1, 1, 16'h6262, 0, n, ma);
    chk(n == 2, "R3 seq hit across column wrap", n, 2);
    do_acc(0, 15, 0, 0, 0, 0, n, ma);
    chk(cpu_rdata == 16'h5151, "R9 read back col 15", int'(cpu_rdata), 16'h5151);
    cpu_req = 0;
    repeat (3) @(negedge clk);
    chk(!cpu_ready && dram_ras_n, "R7 no ready when idle", int'(cpu_ready), 0);
    finish_run();
  end
endmodule